// File: doc/BRIEF.md
# Flash Protected Range Checker

This block holds a small bank of protection-range words and judges every flash access against all of them at once. Each word describes one region of flash in 4 KiB pages, giving a first page, a last page and two independent guards: one that blocks reads and one that blocks writes. An access is presented as a byte address plus a read/write flag. One clock later the block answers allow or deny.

Software programs the words through a plain indexed write port and reads them back through an indexed read port. Reading back lets it confirm that a guard bit took effect. A word that is all zeros counts as unused. The block reports the lowest-numbered unused word so that software can claim it. When an access is denied, a sticky flag is set and the offending address and direction are captured. They stay captured until software clears the flag.

Top module: `prot_range_guard`

## Requirements
- R1: After reset every range word reads back as zero, no access response is signalled, the violation flag is low, and the free-slot output reports slot 0 as available.
- R2: A write on the configuration port with an index below the number of words stores the full 32-bit value, which reads back unchanged on the next cycle, guard bits included; a write with an index at or above the number of words changes nothing and such an index reads back zero.
- R3: Word encoding: bits 14:0 hold the first page, bit 15 is the read guard, bits 30:16 hold the last page and bit 31 is the write guard.
- R4: A region is inclusive at both ends: accesses in the first and the last page are denied, the page just below the first and the page just above the last are allowed.
- R5: A read is denied only by words whose read guard (bit 15) is set; a write is denied only by words whose write guard (bit 31) is set.
- R6: All words are checked in parallel. An access is denied if any guarded word covers it. The verdict appears on the cycle after the access is presented, with exactly one of allow/deny high; with no access both are low.
- R7: The page of an access is its byte address shifted right by 12, so every byte offset inside one page gets the same verdict.
- R8: The free-slot output names the lowest-indexed word that is all zeros, and its valid bit is low when every word is non-zero.
- R9: A denial sets the violation flag in the same cycle as the deny verdict and captures its address and direction; later denials leave the captured values unchanged while the flag stays set.
- R10: A clear drops the flag on the next cycle, unless a denial arrives in the same cycle, in which case the flag stays set and that new denial is captured.
- R11: A word whose two guard bits are both clear never denies an access, even if its page range covers it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Write strobe for a range word |
| cfg_wr_idx | input | IDX_W | Index of the word to write |
| cfg_wr_data | input | 32 | Value to store |
| cfg_rd_idx | input | IDX_W | Index of the word to read back |
| cfg_rd_data | output | 32 | Read-back value (combinational) |
| free_valid | output | 1 | An unused word exists |
| free_idx | output | IDX_W | Lowest unused word index |
| acc_valid | input | 1 | Access presented this cycle |
| acc_addr | input | ADDR_W | Byte address of the access |
| acc_is_write | input | 1 | 1 = write or erase, 0 = read |
| resp_valid | output | 1 | Verdict present (one cycle after the access) |
| resp_allow | output | 1 | Access permitted |
| resp_deny | output | 1 | Access blocked |
| viol_flag | output | 1 | Sticky violation indicator |
| viol_addr | output | ADDR_W | Address of the captured violation |
| viol_is_write | output | 1 | Direction of the captured violation |
| viol_clear | input | 1 | Clear the violation flag |

## Verification
The bench probes the exact first and last pages of a region and the pages just beyond them. A design that treats the last page as exclusive, or compares byte addresses against page numbers, gives the wrong verdict there. It swaps the read and write guards between otherwise identical accesses to catch a design that mixes up bits 15 and 31. It also programs a word with both guards clear over a wide range, which a design that keys on "word non-zero" would wrongly enforce. It fills every slot to check that the free-slot output drops, and writes to an index past the bank to check that nothing changes. It issues denials while the flag is already set, and a denial on the same cycle as a clear, so that a log that overwrites, or lets the clear win, shows a wrong captured address.

// File: rtl/prg_pkg.sv
package prg_pkg;
  localparam int WORD_W     = 32;
  localparam int PAGE_SHIFT = 12;
  localparam int PG_W       = 15;
  localparam int FIRST_LSB  = 0;
  localparam int RD_GUARD   = 15;
  localparam int LAST_LSB   = 16;
  localparam int WR_GUARD   = 31;

  typedef logic [WORD_W-1:0] range_word_t;

  function automatic logic [PG_W-1:0] first_page(range_word_t w);
    return w[FIRST_LSB +: PG_W];
  endfunction

  function automatic logic [PG_W-1:0] last_page(range_word_t w);
    return w[LAST_LSB +: PG_W];
  endfunction

  // Guard that applies to this direction of access.
  function automatic logic guard_for(range_word_t w, logic is_wr);
    return is_wr ? w[WR_GUARD] : w[RD_GUARD];
  endfunction

  // Inclusive page comparison; page is zero-extended page number.
  function automatic logic page_inside(range_word_t w, logic [31:0] page);
    logic [31:0] lo;
    logic [31:0] hi;
    lo = {{(32-PG_W){1'b0}}, first_page(w)};
    hi = {{(32-PG_W){1'b0}}, last_page(w)};
    return (page >= lo) && (page <= hi);
  endfunction
endpackage

// File: rtl/prg_range_bank.sv
module prg_range_bank
  import prg_pkg::*;
#(
  parameter int N     = 5,
  parameter int IDX_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  range_word_t       wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output range_word_t       rd_data,
  output range_word_t       words [N],
  output logic              free_valid,
  output logic [IDX_W-1:0]  free_idx
);
  range_word_t mem [N];
  logic        wr_in_bank;
  logic        rd_in_bank;

  assign wr_in_bank = (int'(wr_idx) < N);
  assign rd_in_bank = (int'(rd_idx) < N);

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rst_n)
          mem[g] <= '0;
        else if (wr_en && wr_in_bank && (int'(wr_idx) == g))
          mem[g] <= wr_data;
      end
      assign words[g] = mem[g];
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N; i++)
      if (rd_in_bank && (int'(rd_idx) == i)) rd_data = mem[i];
  end

  // Lowest all-zero slot: scan downward so the lowest index wins.
  always_comb begin
    free_valid = 1'b0;
    free_idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mem[i] == '0) begin
        free_valid = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
  end

  AST_WRITE_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_in_bank) |=> (mem[$past(wr_idx)] == $past(wr_data))); // R2

  AST_FREE_IS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    free_valid |-> (words[free_idx] == '0)); // R8
endmodule

// File: rtl/prg_match.sv
module prg_match
  import prg_pkg::*;
#(
  parameter int N = 5
) (
  input  range_word_t  words [N],
  input  logic [31:0]  page,
  input  logic         is_wr,
  output logic [N-1:0] hit_vec,
  output logic         any_hit
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_cmp
      assign hit_vec[g] = guard_for(words[g], is_wr) && page_inside(words[g], page);
    end
  endgenerate

  assign any_hit = |hit_vec;
endmodule

// File: rtl/prg_viol_log.sv
module prg_viol_log #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              deny_evt,
  input  logic [ADDR_W-1:0] evt_addr,
  input  logic              evt_is_wr,
  input  logic              clear,
  output logic              flag,
  output logic [ADDR_W-1:0] addr_q,
  output logic              is_wr_q
);
  logic capture;

  // A new denial is captured when nothing is held or the hold is being cleared.
  assign capture = deny_evt && (!flag || clear);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag    <= 1'b0;
      addr_q  <= '0;
      is_wr_q <= 1'b0;
    end else begin
      flag <= (flag && !clear) || deny_evt;
      if (capture) begin
        addr_q  <= evt_addr;
        is_wr_q <= evt_is_wr;
      end
    end
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clear) |=> flag); // R9

  AST_CAPTURE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clear) |=> ($stable(addr_q) && $stable(is_wr_q))); // R9

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && !deny_evt) |=> !flag); // R10
endmodule

// File: rtl/prot_range_guard.sv
module prot_range_guard
  import prg_pkg::*;
#(
  parameter int N_RANGES = 5,
  parameter int ADDR_W   = 32,
  localparam int IDX_W   = (N_RANGES > 1) ? $clog2(N_RANGES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [IDX_W-1:0]  cfg_wr_idx,
  input  logic [31:0]       cfg_wr_data,
  input  logic [IDX_W-1:0]  cfg_rd_idx,
  output logic [31:0]       cfg_rd_data,
  output logic              free_valid,
  output logic [IDX_W-1:0]  free_idx,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_is_write,
  output logic              resp_valid,
  output logic              resp_allow,
  output logic              resp_deny,
  output logic              viol_flag,
  output logic [ADDR_W-1:0] viol_addr,
  output logic              viol_is_write,
  input  logic              viol_clear
);
  range_word_t          words [N_RANGES];
  logic [31:0]          acc_page;
  logic [N_RANGES-1:0]  hit_vec;
  logic                 any_hit;
  logic                 deny_evt;
  logic                 allow_evt;

  prg_range_bank #(.N(N_RANGES), .IDX_W(IDX_W)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cfg_wr_en),
    .wr_idx     (cfg_wr_idx),
    .wr_data    (cfg_wr_data),
    .rd_idx     (cfg_rd_idx),
    .rd_data    (cfg_rd_data),
    .words      (words),
    .free_valid (free_valid),
    .free_idx   (free_idx)
  );

  assign acc_page = 32'(acc_addr >> PAGE_SHIFT);

  prg_match #(.N(N_RANGES)) u_match (
    .words   (words),
    .page    (acc_page),
    .is_wr   (acc_is_write),
    .hit_vec (hit_vec),
    .any_hit (any_hit)
  );

  assign deny_evt  = acc_valid && any_hit;
  assign allow_evt = acc_valid && !any_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_allow <= 1'b0;
      resp_deny  <= 1'b0;
    end else begin
      resp_valid <= acc_valid;
      resp_allow <= allow_evt;
      resp_deny  <= deny_evt;
    end
  end

  prg_viol_log #(.ADDR_W(ADDR_W)) u_log (
    .clk       (clk),
    .rst_n     (rst_n),
    .deny_evt  (deny_evt),
    .evt_addr  (acc_addr),
    .evt_is_wr (acc_is_write),
    .clear     (viol_clear),
    .flag      (viol_flag),
    .addr_q    (viol_addr),
    .is_wr_q   (viol_is_write)
  );

  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_allow != resp_deny)); // R6

  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_valid |-> (!resp_allow && !resp_deny)); // R6

  AST_DENY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    resp_deny |-> viol_flag); // R9

  AST_UNGUARDED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && (words[0][RD_GUARD] == 1'b0) && (words[0][WR_GUARD] == 1'b0)) |-> !hit_vec[0]); // R11
endmodule

// File: tb/tb_prot_range_guard.sv
module tb_prot_range_guard;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 5;
  localparam int AW  = 32;
  localparam int IW  = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_wr_en;
  logic [IW-1:0] cfg_wr_idx;
  logic [31:0]   cfg_wr_data;
  logic [IW-1:0] cfg_rd_idx;
  logic [31:0]   cfg_rd_data;
  logic          free_valid;
  logic [IW-1:0] free_idx;
  logic          acc_valid;
  logic [AW-1:0] acc_addr;
  logic          acc_is_write;
  logic          resp_valid, resp_allow, resp_deny;
  logic          viol_flag;
  logic [AW-1:0] viol_addr;
  logic          viol_is_write;
  logic          viol_clear;

  int checks = 0;
  int fails  = 0;

  // Reference model state
  logic [31:0] mw [N];
  logic        m_rv, m_al, m_dn, m_flag, m_vw;
  logic [31:0] m_va;

  always #(CLK_PERIOD/2) clk = ~clk;

  prot_range_guard #(.N_RANGES(N), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_idx(cfg_wr_idx), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_idx(cfg_rd_idx), .cfg_rd_data(cfg_rd_data),
    .free_valid(free_valid), .free_idx(free_idx),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_is_write(acc_is_write),
    .resp_valid(resp_valid), .resp_allow(resp_allow), .resp_deny(resp_deny),
    .viol_flag(viol_flag), .viol_addr(viol_addr), .viol_is_write(viol_is_write),
    .viol_clear(viol_clear)
  );

  task automatic check(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit model_denies(logic [31:0] addr, bit isw);
    int unsigned page;
    bit d;
    page = addr >> 12;
    d = 0;
    for (int i = 0; i < N; i++) begin
      int unsigned lo, hi;
      bit g;
      lo = mw[i] & 32'h7FFF;
      hi = (mw[i] >> 16) & 32'h7FFF;
      g  = isw ? mw[i][31] : mw[i][15];
      if (g && page >= lo && page <= hi) d = 1;
    end
    return d;
  endfunction

  // One cycle: drive, advance model, compare at the following negedge.
  task automatic cyc(string tag, bit we, int widx, logic [31:0] wd,
                     bit av, logic [31:0] a, bit isw, bit clr, int ridx);
    bit d;
    bit fv;
    int fi;
    logic [31:0] exp_rd;
    cfg_wr_en = we; cfg_wr_idx = IW'(widx); cfg_wr_data = wd;
    acc_valid = av; acc_addr = a; acc_is_write = isw;
    viol_clear = clr; cfg_rd_idx = IW'(ridx);
    d = av && model_denies(a, isw);
    m_rv = av; m_dn = d; m_al = av && !d;
    if (d && (!m_flag || clr)) begin m_va = a; m_vw = isw; end
    m_flag = (m_flag && !clr) || d;
    if (we && widx < N) mw[widx] = wd;
    @(posedge clk);
    @(negedge clk);
    check(tag, "resp_valid", resp_valid, m_rv);
    check(tag, "resp_allow", resp_allow, m_al);
    check(tag, "resp_deny",  resp_deny,  m_dn);
    check(tag == "R10" ? "R10" : "R9", "viol_flag", viol_flag, m_flag);
    if (m_flag) begin
      check(tag == "R10" ? "R10" : "R9", "viol_addr", viol_addr, m_va);
      check("R9", "viol_is_write", viol_is_write, m_vw);
    end
    exp_rd = (ridx < N) ? mw[ridx] : 32'h0;
    check(tag == "R1" ? "R1" : "R2", "cfg_rd_data", cfg_rd_data, exp_rd);
    fv = 0; fi = 0;
    for (int i = N - 1; i >= 0; i--) if (mw[i] == 0) begin fv = 1; fi = i; end
    check(tag == "R1" ? "R1" : "R8", "free_valid", free_valid, fv);
    if (fv) check("R8", "free_idx", free_idx, fi);
  endtask

  task automatic acc(string tag, logic [31:0] a, bit isw);
    cyc(tag, 0, 0, 0, 1, a, isw, 0, 0);
  endtask

  task automatic prog(string tag, int idx, logic [31:0] w);
    cyc(tag, 1, idx, w, 0, 0, 0, 0, idx);
  endtask

  function automatic logic [31:0] mk(int lo, int hi, bit rg, bit wg);
    return {wg, 15'(hi), rg, 15'(lo)};
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) mw[i] = 0;
    m_flag = 0; m_va = 0; m_vw = 0;
    rst_n = 0; cfg_wr_en = 0; cfg_wr_idx = 0; cfg_wr_data = 0; cfg_rd_idx = 0;
    acc_valid = 0; acc_addr = 0; acc_is_write = 0; viol_clear = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1: reset state, every slot reads zero
    for (int i = 0; i < N; i++) cyc("R1", 0, 0, 0, 0, 0, 0, 0, i);
    check("R1", "viol_flag", viol_flag, 0);

    // R3: write guard only, pages 0x10..0x1F in slot 0
    prog("R3", 0, mk(16'h10, 16'h1F, 0, 1));
    check("R3", "first page field", cfg_rd_data[14:0], 15'h10);
    check("R3", "last page field", cfg_rd_data[30:16], 15'h1F);
    check("R3", "write guard bit", cfg_rd_data[31], 1);
    acc("R4", 32'h0001_0000, 1);   // first page, write -> deny
    acc("R5", 32'h0001_0000, 0);   // read, no read guard -> allow
    acc("R4", 32'h0001_FFFF, 1);   // last byte of last page -> deny
    acc("R4", 32'h0002_0000, 1);   // page above -> allow
    acc("R4", 32'h0000_FFFF, 1);   // page below -> allow
    acc("R7", 32'h0001_5ABC, 1);   // mid-page offset -> deny
    acc("R7", 32'h0001_5001, 1);
    // R10: clear, then clear alongside a new denial
    cyc("R10", 0, 0, 0, 0, 0, 0, 1, 0);
    cyc("R10", 0, 0, 0, 1, 32'h0001_8004, 1, 0, 0);
    cyc("R10", 0, 0, 0, 1, 32'h0001_9008, 1, 1, 0);
    cyc("R10", 0, 0, 0, 0, 0, 0, 1, 0);

    // R5: single-page read guard in slot 1
    prog("R5", 1, mk(16'h40, 16'h40, 1, 0));
    acc("R5", 32'h0004_0123, 0);
    acc("R5", 32'h0004_0123, 1);
    // R11: unguarded wide range in slot 2
    prog("R11", 2, mk(16'h0, 16'h7FFF, 0, 0));
    acc("R11", 32'h0300_0000, 0);
    acc("R11", 32'h0300_0000, 1);
    // R6: overlapping write-guarded ranges, fill bank
    prog("R6", 3, mk(16'h100, 16'h200, 0, 1));
    prog("R8", 4, mk(16'h150, 16'h300, 1, 1));
    acc("R6", 32'h0025_0000, 1);   // only slot 4 covers
    acc("R6", 32'h0018_0000, 0);   // slot 4 read guard
    acc("R6", 32'h0030_1000, 1);   // beyond both -> allow
    acc("R6", 32'h07FF_F000, 1);   // top page, unguarded
    // R2: out-of-bank write ignored
    cyc("R2", 1, 7, 32'hDEAD_BEEF, 0, 0, 0, 0, 7);
    for (int i = 0; i < N; i++) cyc("R2", 0, 0, 0, 0, 0, 0, 0, i);
    // R8: releasing slot 0 makes it the free slot
    prog("R8", 0, 32'h0);
    acc("R8", 32'h0001_0000, 1);
    cyc("R9", 0, 0, 0, 0, 0, 0, 0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule